// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This controller watches eight interrupt request lines and signals the processor when a request needs service. It captures each rising edge on a line as a pending request and resolves the pending requests by fixed priority. Line 0 ranks highest, and rank falls as the line number rises.

When the processor acknowledges, the controller returns a vector number equal to a programmed base plus the winning line index. It also marks that line as in service. A level in service holds back every request of equal or lower rank until software sends an end-of-interrupt command. A request of higher rank can still interrupt the handler, so handlers may nest.

The base is loaded by an initialization write, and the controller stays silent until that write has been made. Two copies, programmed with bases such as 08h and 70h, together serve sixteen lines.

Top module: `vec_prio_intc`

## Requirements
- R1: After reset, and until the first initialization write, `irq` stays low and rising edges on `req_in` are not recorded.
- R2: When several requests are pending, the lowest-numbered line wins both the arbitration and the acknowledge.
- R3: An acknowledge taken while `irq` is high raises `vec_valid` for one cycle, starting on the following cycle. In that cycle `vec_out` equals the programmed base plus the winning line index, modulo 256. The value stays on `vec_out` until the next acknowledge.
- R4: A pending request whose line is equal to or lower in rank than an in-service line does not raise `irq`.
- R5: A pending request that outranks every in-service line raises `irq` even while other lines are in service, and acknowledging it nests a second in-service level.
- R6: An `eoi_cmd` pulse clears only the highest-ranked in-service line, so a lower-ranked line that was pending behind it may then signal.
- R7: A request is recorded only on a 0-to-1 change of its line. A line held high records once, and acknowledging it clears the request.
- R8: An acknowledge taken while `irq` is low is ignored: `vec_valid` stays low and no state changes.
- R9: An initialization write loads a new base and clears all pending and in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 8 | Interrupt request lines, bit 0 highest rank |
| init_we | input | 1 | Initialization write strobe |
| init_base | input | 8 | Vector base loaded by `init_we` |
| int_ack | input | 1 | Processor acknowledge, sampled on the clock edge |
| eoi_cmd | input | 1 | End-of-interrupt command pulse |
| irq | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | One-cycle strobe marking a fresh vector |
| vec_out | output | 8 | Vector number: base plus line index |

## Verification
The assertions assume `init_we` is never raised in the same cycle as `int_ack` or `eoi_cmd`. They also assume end-of-interrupt and acknowledge never coincide, because the in-service count checks rely on exactly one of those events per cycle. The stimulus drives every strobe as an isolated single-cycle pulse, placed two nanoseconds after a clock edge. It spaces initialization writes apart from all acknowledge and end-of-interrupt activity. `req_in` toggles freely, including while lines are in service and before initialization, because the design places no restriction on it.

// File: rtl/vec_prio_intc.sv
module vec_prio_intc #(
  parameter int N  = 8,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_in,
  input  logic          init_we,
  input  logic [VW-1:0] init_base,
  input  logic          int_ack,
  input  logic          eoi_cmd,
  output logic          irq,
  output logic          vec_valid,
  output logic [VW-1:0] vec_out
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic          armed;
  logic [VW-1:0] base_q;
  logic [N-1:0]  req_d, pend_q, isr_q;
  logic [VW-1:0] vec_q;
  logic          vld_q;

  function automatic logic [IW-1:0] first_set(input logic [N-1:0] v);
    first_set = '0;
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) first_set = IW'(i);
  endfunction

  wire [IW-1:0] pend_idx = first_set(pend_q);
  wire [IW-1:0] isr_idx  = first_set(isr_q);
  wire          pend_any = |pend_q;
  wire          isr_any  = |isr_q;
  wire          outranks = pend_any && (!isr_any || pend_idx < isr_idx);
  wire          grant    = int_ack && irq;

  wire [N-1:0] edges      = req_in & ~req_d;
  wire [N-1:0] grant_mask = grant ? (N'(1) << pend_idx) : '0;
  wire [N-1:0] eoi_mask   = (eoi_cmd && isr_any) ? (N'(1) << isr_idx) : '0;

  assign irq       = armed && outranks;
  assign vec_valid = vld_q;
  assign vec_out   = vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      base_q <= '0;
      req_d  <= '0;
      pend_q <= '0;
      isr_q  <= '0;
      vec_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      req_d <= req_in;
      if (init_we) begin
        armed  <= 1'b1;
        base_q <= init_base;
        pend_q <= '0;
        isr_q  <= '0;
        vld_q  <= 1'b0;
      end else begin
        pend_q <= (pend_q & ~grant_mask) | (armed ? edges : '0);
        isr_q  <= (isr_q & ~eoi_mask) | grant_mask;
        vld_q  <= grant;
        if (grant) vec_q <= base_q + VW'(pend_idx);
      end
    end
  end
endmodule

module vec_prio_intc_chk #(
  parameter int N  = 8,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          armed,
  input logic          irq,
  input logic          int_ack,
  input logic          eoi_cmd,
  input logic          init_we,
  input logic          vec_valid,
  input logic [VW-1:0] vec_out,
  input logic [VW-1:0] base_q,
  input logic [N-1:0]  pend_q,
  input logic [N-1:0]  isr_q
);
  AST_SILENT_UNTIL_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !irq); // R1
  AST_VEC_NEAR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (VW'(vec_out - base_q) < VW'(N))); // R3
  AST_VALID_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(int_ack && irq)); // R8
  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_q != '0)); // R4
  AST_ACK_NESTS: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && irq && !eoi_cmd && !init_we) |=>
      $countones(isr_q) == $past($countones(isr_q)) + 1); // R5
  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_cmd && !(int_ack && irq) && !init_we && isr_q != '0) |=>
      $countones(isr_q) == $past($countones(isr_q)) - 1); // R6
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    init_we |=> (isr_q == '0 && !vec_valid)); // R9
endmodule

bind vec_prio_intc vec_prio_intc_chk #(.N(N), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .irq(irq), .int_ack(int_ack),
  .eoi_cmd(eoi_cmd), .init_we(init_we), .vec_valid(vec_valid),
  .vec_out(vec_out), .base_q(base_q), .pend_q(pend_q), .isr_q(isr_q));

// File: tb/tb_vec_prio_intc.sv
`timescale 1ns/1ps
module tb_vec_prio_intc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_in = '0;
  logic       init_we = 1'b0;
  logic [7:0] init_base = '0;
  logic       int_ack = 1'b0;
  logic       eoi_cmd = 1'b0;
  logic       irq, vec_valid;
  logic [7:0] vec_out;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vec_prio_intc dut (.clk(clk), .rst_n(rst_n), .req_in(req_in), .init_we(init_we),
    .init_base(init_base), .int_ack(int_ack), .eoi_cmd(eoi_cmd), .irq(irq),
    .vec_valid(vec_valid), .vec_out(vec_out));

  // behavioural reference
  int  m_armed, m_base, m_vld, m_vec;
  int  m_pend[8], m_isr[8], m_prev[8];

  function automatic int low_pend();
    for (int i = 0; i < 8; i++) if (m_pend[i] != 0) return i;
    return -1;
  endfunction
  function automatic int low_isr();
    for (int i = 0; i < 8; i++) if (m_isr[i] != 0) return i;
    return -1;
  endfunction
  function automatic int m_irq();
    int p, s;
    p = low_pend();
    s = low_isr();
    return (m_armed != 0 && p >= 0 && (s < 0 || p < s)) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    int p, s, g;
    if (!rst_n) begin
      m_armed = 0; m_base = 0; m_vld = 0; m_vec = 0;
      for (int i = 0; i < 8; i++) begin m_pend[i] = 0; m_isr[i] = 0; m_prev[i] = 0; end
    end else begin
      p = low_pend();
      s = low_isr();
      g = (int_ack && m_irq() != 0) ? 1 : 0;
      if (init_we) begin
        m_armed = 1; m_base = init_base; m_vld = 0;
        for (int i = 0; i < 8; i++) begin m_pend[i] = 0; m_isr[i] = 0; end
      end else begin
        if (eoi_cmd && s >= 0) m_isr[s] = 0;
        if (g != 0) begin
          m_isr[p] = 1; m_pend[p] = 0; m_vec = (m_base + p) % 256;
        end
        m_vld = g;
        for (int i = 0; i < 8; i++)
          if (m_armed != 0 && req_in[i] && m_prev[i] == 0) m_pend[i] = 1;
      end
      for (int i = 0; i < 8; i++) m_prev[i] = req_in[i];
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R4 irq vs model", irq, m_irq());
    chk("R3 vec_valid vs model", vec_valid, m_vld);
    chk("R3 vec_out vs model", vec_out, m_vec);
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask
  task automatic pulse_init(input logic [7:0] b);
    init_base = b; init_we = 1'b1; step(1); init_we = 1'b0; step(1);
  endtask
  task automatic ack_expect(input string tag, input int exp_vec);
    int_ack = 1'b1; step(1); int_ack = 1'b0;
    @(negedge clk);
    chk(tag, vec_valid, 1);
    chk(tag, vec_out, exp_vec);
    step(1);
  endtask
  task automatic eoi();
    eoi_cmd = 1'b1; step(1); eoi_cmd = 1'b0; step(1);
  endtask
  task automatic irq_expect(input string tag, input int exp);
    @(negedge clk); chk(tag, irq, exp); step(0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    step(1);
    irq_expect("R1 reset irq", 0);
    chk("R1 reset vec_valid", vec_valid, 0);
    req_in[2] = 1'b1; step(3); req_in[2] = 1'b0;
    irq_expect("R1 edge before init ignored", 0);

    pulse_init(8'h08);
    irq_expect("R1 nothing recorded before init", 0);
    int_ack = 1'b1; step(1); int_ack = 1'b0;
    @(negedge clk); chk("R8 ack with irq low", vec_valid, 0); step(0);

    req_in[3] = 1'b1; step(1);
    irq_expect("R7 rising edge raises irq", 1);
    ack_expect("R3 vector 0Bh for line 3", 8'h0B);
    step(3);
    irq_expect("R7 held line does not retrigger", 0);
    req_in[5] = 1'b1; step(2);
    irq_expect("R4 lower rank held", 0);
    req_in[3] = 1'b0; step(1); req_in[3] = 1'b1; step(2);
    irq_expect("R4 equal rank held", 0);
    req_in[1] = 1'b1; step(1);
    irq_expect("R5 higher rank nests", 1);
    ack_expect("R5 nested vector 09h", 8'h09);
    irq_expect("R4 still blocked under two levels", 0);
    eoi();
    irq_expect("R6 eoi removes only line 1", 0);
    eoi();
    irq_expect("R6 line 3 signals after eoi", 1);
    ack_expect("R2 line 3 before line 5", 8'h0B);
    eoi();
    ack_expect("R3 vector 0Dh for line 5", 8'h0D);
    eoi();
    irq_expect("R7 acknowledged requests cleared", 0);

    req_in = 8'h00; step(2);
    req_in = 8'h50; step(1);
    ack_expect("R2 line 4 beats line 6", 8'h0C);
    eoi();
    ack_expect("R2 line 6 follows", 8'h0E);
    eoi();

    req_in = 8'h00; step(2);
    req_in = 8'h81; step(1);
    ack_expect("R3 line 0 before reinit", 8'h08);
    pulse_init(8'h70);
    irq_expect("R9 reinit clears pending", 0);
    req_in = 8'h00; step(2);
    req_in = 8'h80; step(1);
    ack_expect("R9 new base line 7 gives 77h", 8'h77);
    req_in[0] = 1'b1; step(1);
    irq_expect("R9 in-service cleared, line 0 nests", 1);
    ack_expect("R3 line 0 gives 70h", 8'h70);
    eoi(); eoi();
    irq_expect("R6 all levels ended", 0);
    step(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule